// File: doc/BRIEF.md
# Out-of-Order Dispatch Queue with Runtime-Sized Issue Width

This block sits between an instruction decoder and a pool of execution units. It takes decoded instructions into an eight-entry circular queue and notes which source registers each one reads and which register it writes. An entry may issue once no older entry still owes a result for any register it reads. Issue is oldest-first and out of order. Retirement leaves the queue in allocation order, one entry per cycle.

The number of units of each kind is not fixed. A configuration controller drives one availability bit per issue port. Each kind of unit (integer ALU, integer multiply/divide, load/store) owns a group of ports. A port whose bit is low gets no new work. Work already handed to that unit may still report its writeback, and the queue accepts it. The queue index of an entry is its tag. Units return that tag with their writeback.

Top module: `rob_dispatch`

## Requirements
- R1: The queue holds 8 entries. `in_ready` is low while 8 entries are held. An `in_valid` pulse while `in_ready` is low adds nothing.
- R2: Tags are handed out in allocation order modulo 8, starting at 0 after reset. Tags wrap from 7 back to 0.
- R3: Issue port p (p = type*2 + unit) raises `iss_valid[p]` only while `avail[p]` is 1.
- R4: An entry issues at most once. Two ports never carry the same tag in the same cycle.
- R5: Among ready entries of one type, the oldest goes to the lowest-numbered available port of that type, the next oldest to the next port, and so on.
- R6: An entry whose enabled source matches the enabled destination of an older entry that has not yet written back does not issue.
- R7: Commit releases at most one entry per cycle. It releases only the oldest entry, and only after that entry has written back. Tags therefore commit in allocation order even when writebacks arrive out of order.
- R8: Type codes are 0 for the integer ALU (ports 0 and 1), 1 for multiply/divide (ports 2 and 3) and 2 for load/store (ports 4 and 5). An entry issues only on a port of its own type.
- R9: A writeback for an issued entry completes that entry even if its unit's availability bit has since dropped.
- R10: After reset the queue is empty. `in_ready` is 1, and no issue or commit is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | Queue has a free entry |
| in_type | input | 2 | Unit type code |
| in_dst | input | 3 | Destination register |
| in_dst_en | input | 1 | Destination is written |
| in_src1 | input | 3 | First source register |
| in_src1_en | input | 1 | First source is read |
| in_src2 | input | 3 | Second source register |
| in_src2_en | input | 1 | Second source is read |
| avail | input | 6 | Per-port availability from the configuration controller |
| iss_valid | output | 6 | Issue strobe per port |
| iss_tag | output | 18 | Tag per port, 3 bits each, port p at bits 3p+2..3p |
| wb_valid | input | 2 | Writeback strobes |
| wb_tag | input | 6 | Writeback tags, 3 bits each |
| cmt_valid | output | 1 | Oldest entry retires this cycle |
| cmt_tag | output | 3 | Tag of the retiring entry |
| cmt_dst | output | 3 | Destination of the retiring entry |
| cmt_dst_en | output | 1 | Retiring entry writes a register |

## Verification
The awkward case is an issue decision that depends on many entries being queued at once. While the availability bits are low, nothing drains, so the bench first loads the queue with every port disabled. It then opens a chosen set of ports in a single step and compares the very first issue cycle against the expected port and tag pattern. The same holding trick fills the queue to capacity for the stall test. It also lets writebacks be returned in reverse order, which shows that commit still waits for the oldest entry.

// File: rtl/rob_dispatch.sv
module rob_dispatch #(
  parameter int DEPTH = 8,
  parameter int NREG  = 8,
  parameter int NTYPE = 3,
  parameter int MAXU  = 2,
  parameter int WBN   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [$clog2(NTYPE)-1:0]    in_type,
  input  logic [$clog2(NREG)-1:0]     in_dst,
  input  logic                        in_dst_en,
  input  logic [$clog2(NREG)-1:0]     in_src1,
  input  logic                        in_src1_en,
  input  logic [$clog2(NREG)-1:0]     in_src2,
  input  logic                        in_src2_en,
  input  logic [NTYPE*MAXU-1:0]       avail,
  output logic [NTYPE*MAXU-1:0]       iss_valid,
  output logic [NTYPE*MAXU*$clog2(DEPTH)-1:0] iss_tag,
  input  logic [WBN-1:0]              wb_valid,
  input  logic [WBN*$clog2(DEPTH)-1:0] wb_tag,
  output logic                        cmt_valid,
  output logic [$clog2(DEPTH)-1:0]    cmt_tag,
  output logic [$clog2(NREG)-1:0]     cmt_dst,
  output logic                        cmt_dst_en
);
  localparam int TW  = $clog2(DEPTH);
  localparam int RW  = $clog2(NREG);
  localparam int YW  = $clog2(NTYPE);
  localparam int NP  = NTYPE * MAXU;

  logic [DEPTH-1:0] vld, sent, done, de, s1e, s2e, rdy, pick;
  logic [YW-1:0]    ty  [DEPTH];
  logic [RW-1:0]    dst [DEPTH];
  logic [RW-1:0]    s1  [DEPTH];
  logic [RW-1:0]    s2  [DEPTH];
  logic [TW-1:0]    head, tail;
  logic [TW:0]      cnt;

  wire full = (cnt == (TW+1)'(DEPTH));
  assign in_ready   = !full;
  wire alloc = in_valid && in_ready;
  assign cmt_valid  = vld[head] && done[head];
  assign cmt_tag    = head;
  assign cmt_dst    = dst[head];
  assign cmt_dst_en = de[head];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic [TW-1:0] ai, aj;
      ai = TW'(TW'(i) - head);
      rdy[i] = vld[i] && !sent[i];
      for (int j = 0; j < DEPTH; j++) begin
        aj = TW'(TW'(j) - head);
        if (aj < ai && vld[j] && de[j] && !done[j] &&
            ((s1e[i] && dst[j] == s1[i]) || (s2e[i] && dst[j] == s2[i])))
          rdy[i] = 1'b0;
      end
    end
  end

  always_comb begin
    iss_valid = '0;
    iss_tag   = '0;
    pick      = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [TW-1:0] e;
      logic taken;
      e = TW'(head + TW'(k));
      taken = 1'b0;
      for (int p = 0; p < NP; p++) begin
        if (!taken && rdy[e] && avail[p] && !iss_valid[p] && ty[e] == YW'(p / MAXU)) begin
          iss_valid[p] = 1'b1;
          iss_tag[p*TW +: TW] = e;
          pick[e] = 1'b1;
          taken = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0; sent <= '0; done <= '0; de <= '0; s1e <= '0; s2e <= '0;
      head <= '0; tail <= '0; cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ty[i] <= '0; dst[i] <= '0; s1[i] <= '0; s2[i] <= '0;
      end
    end else begin
      sent <= sent | pick;
      for (int w = 0; w < WBN; w++)
        if (wb_valid[w] && vld[wb_tag[w*TW +: TW]]) done[wb_tag[w*TW +: TW]] <= 1'b1;
      if (cmt_valid) begin
        vld[head] <= 1'b0;
        head <= TW'(head + 1'b1);
      end
      if (alloc) begin
        vld[tail] <= 1'b1; sent[tail] <= 1'b0; done[tail] <= 1'b0;
        ty[tail] <= in_type; dst[tail] <= in_dst; de[tail] <= in_dst_en;
        s1[tail] <= in_src1; s1e[tail] <= in_src1_en;
        s2[tail] <= in_src2; s2e[tail] <= in_src2_en;
        tail <= TW'(tail + 1'b1);
      end
      cnt <= cnt + (TW+1)'(alloc) - (TW+1)'(cmt_valid);
    end
  end

  p_full_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid) |=> $stable(tail));

  p_port_avail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid & ~avail) == '0);

  p_commit_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && $past(cmt_valid)) |-> cmt_tag == TW'($past(cmt_tag) + 1'b1));

  genvar ga, gb;
  for (ga = 0; ga < NP; ga++) begin : g_pa
    for (gb = ga + 1; gb < NP; gb++) begin : g_pb
      p_uniq_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid[ga] && iss_valid[gb]) |-> iss_tag[ga*TW +: TW] != iss_tag[gb*TW +: TW]);
    end
  end
endmodule

// File: tb/rob_dispatch_tb_top.sv
module rob_dispatch_tb_top;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_dst_en = 0, in_src1_en = 0, in_src2_en = 0;
  logic [1:0] in_type = 0;
  logic [2:0] in_dst = 0, in_src1 = 0, in_src2 = 0;
  logic [5:0] avail = 0, iss_valid;
  logic [17:0] iss_tag;
  logic [1:0] wb_valid = 0;
  logic [5:0] wb_tag = 0;
  logic cmt_valid, cmt_dst_en;
  logic [2:0] cmt_tag, cmt_dst;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  rob_dispatch dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_type(in_type), .in_dst(in_dst), .in_dst_en(in_dst_en), .in_src1(in_src1),
    .in_src1_en(in_src1_en), .in_src2(in_src2), .in_src2_en(in_src2_en), .avail(avail),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_dst(cmt_dst), .cmt_dst_en(cmt_dst_en));

  // {avail, expected issue mask, tag on port 0, tag on port 1}; three ALU entries queued
  localparam logic [17:0] VEC [6] = '{
    {6'b000001, 6'b000001, 3'd0, 3'd0},
    {6'b000010, 6'b000010, 3'd0, 3'd0},
    {6'b000011, 6'b000011, 3'd0, 3'd1},
    {6'b000000, 6'b000000, 3'd0, 3'd0},
    {6'b111111, 6'b000011, 3'd0, 3'd1},
    {6'b111100, 6'b000000, 3'd0, 3'd0}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0; avail = 0; wb_valid = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic enq(input logic [1:0] t, input logic [2:0] d, input logic den,
                     input logic [2:0] a, input logic ae);
    in_type = t; in_dst = d; in_dst_en = den; in_src1 = a; in_src1_en = ae;
    in_src2 = 0; in_src2_en = 0; in_valid = 1;
    tick();
    in_valid = 0;
  endtask

  task automatic wb1(input logic [2:0] t);
    wb_valid = 2'b01; wb_tag = {3'd0, t};
    tick();
    wb_valid = 0;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset(); #1;
    chk(in_ready, "R10 in_ready", in_ready, 1);
    chk(iss_valid == 0, "R10 iss_valid", iss_valid, 0);
    chk(!cmt_valid, "R10 cmt_valid", cmt_valid, 0);

    // R5 R3: oldest first onto lowest available ALU port
    for (int r = 0; r < 6; r++) begin
      do_reset();
      for (int k = 0; k < 3; k++) enq(2'd0, 3'd0, 1'b0, 3'd0, 1'b0);
      avail = VEC[r][17:12]; #1;
      chk(iss_valid == VEC[r][11:6], "R3 R5 issue mask", iss_valid, VEC[r][11:6]);
      if (VEC[r][6]) chk(iss_tag[2:0] == VEC[r][5:3], "R5 port0 tag", iss_tag[2:0], VEC[r][5:3]);
      if (VEC[r][7]) chk(iss_tag[5:3] == VEC[r][2:0], "R5 port1 tag", iss_tag[5:3], VEC[r][2:0]);
    end

    // R1 R2 R7: fill, stall, drain in order, wrap
    do_reset();
    for (int k = 0; k < 8; k++) enq(2'd0, 3'(k), 1'b1, 3'd0, 1'b0);
    #1 chk(!in_ready, "R1 full stall", in_ready, 0);
    in_valid = 1; tick(); in_valid = 0; #1;
    chk(!in_ready, "R1 ignored push", in_ready, 0);
    begin
      int ncm;
      ncm = 0;
      for (int c = 0; c < 14; c++) begin
        if (c < 4) begin wb_valid = 2'b11; wb_tag = {3'(2*c+1), 3'(2*c)}; end
        else wb_valid = 0;
        #1;
        if (cmt_valid) begin
          chk(cmt_tag == 3'(ncm), "R7 R2 commit order", cmt_tag, ncm);
          ncm++;
        end
        tick();
      end
      chk(ncm == 8, "R1 R7 commit count", ncm, 8);
    end
    chk(in_ready, "R1 drained", in_ready, 1);
    enq(2'd0, 3'd0, 1'b0, 3'd0, 1'b0);
    avail = 6'b000001; #1;
    chk(iss_valid == 6'b000001 && iss_tag[2:0] == 3'd0, "R2 tag wrap", iss_tag[2:0], 0);

    // R7: out-of-order writeback, in-order commit
    do_reset();
    for (int k = 0; k < 3; k++) enq(2'd0, 3'd0, 1'b0, 3'd0, 1'b0);
    wb1(3'd2); wb1(3'd1); #1;
    chk(!cmt_valid, "R7 head not done", cmt_valid, 0);
    wb1(3'd0); #1;
    chk(cmt_valid && cmt_tag == 0, "R7 commit 0", cmt_tag, 0);
    tick(); #1 chk(cmt_valid && cmt_tag == 1, "R7 commit 1", cmt_tag, 1);
    tick(); #1 chk(cmt_valid && cmt_tag == 2, "R7 commit 2", cmt_tag, 2);
    tick(); #1 chk(!cmt_valid, "R7 one per cycle empty", cmt_valid, 0);

    // R6 R4: dependency blocks, no reissue
    do_reset();
    enq(2'd0, 3'd3, 1'b1, 3'd0, 1'b0);
    enq(2'd0, 3'd4, 1'b1, 3'd3, 1'b1);
    enq(2'd0, 3'd5, 1'b1, 3'd1, 1'b1);
    avail = 6'b000011; #1;
    chk(iss_valid == 6'b000011, "R6 mask", iss_valid, 3);
    chk(iss_tag[2:0] == 0 && iss_tag[5:3] == 2, "R6 skip dependent", iss_tag[5:0], 16);
    tick(); #1;
    chk(iss_valid == 0, "R6 R4 blocked and no reissue", iss_valid, 0);
    wb1(3'd0); #1;
    chk(iss_valid == 6'b000001 && iss_tag[2:0] == 1, "R6 wake after writeback", iss_tag[2:0], 1);

    // R8: type steering
    do_reset();
    enq(2'd1, 3'd0, 1'b0, 3'd0, 1'b0);
    enq(2'd2, 3'd0, 1'b0, 3'd0, 1'b0);
    enq(2'd0, 3'd0, 1'b0, 3'd0, 1'b0);
    avail = 6'b111111; #1;
    chk(iss_valid == 6'b010101, "R8 mask", iss_valid, 21);
    chk(iss_tag[8:6] == 0 && iss_tag[14:12] == 1 && iss_tag[2:0] == 2, "R8 tags", iss_tag, 0);

    // R9 R3: unit removed while in flight
    do_reset();
    enq(2'd0, 3'd0, 1'b0, 3'd0, 1'b0);
    enq(2'd0, 3'd0, 1'b0, 3'd0, 1'b0);
    #1 chk(iss_valid == 0, "R3 nothing available", iss_valid, 0);
    avail = 6'b000001; #1;
    chk(iss_valid == 6'b000001 && iss_tag[2:0] == 0, "R3 single port", iss_valid, 1);
    tick(); avail = 0; #1;
    chk(iss_valid == 0, "R3 removed unit idle", iss_valid, 0);
    wb1(3'd0); #1;
    chk(cmt_valid && cmt_tag == 0, "R9 in-flight completes", cmt_tag, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule